// File: doc/BRIEF.md
# Event-Driven PWM Output Generator

This block drives a single pulse-width-modulated output from a 16-bit counter and two compare values. The counter runs in one of two shapes. In sawtooth mode it counts down to zero and then reloads from a period register. In triangle mode it climbs from zero to the period value and then falls back to zero. On every clock the block looks at the current count and flags up to six events: the count is zero, the count equals the period, or the count equals compare A or compare B. Each compare match is split into a rising-slope event and a falling-slope event.

A 12-bit action word assigns a 2-bit action to each of the six events. When several events land in the same cycle, fixed priority rules choose one of them. The chosen action then sets, clears, toggles or holds the output register.

Software configures the block through a narrow write-only port. The port sets the period, both compare values, the counting mode and the action word. A generator enable starts the counter. Dropping the enable parks the counter and forces the output low.

Top module: `pwm_event_gen`

## Requirements
- R1: After reset, `pwm_out` is 0, `cnt_value` is 0, and the period, both compares, the mode and the action word are all 0, so every event holds the output.
- R2: A write with `wr_en`=1 takes effect on the next clock edge. Addresses: 0 = period (data bits 15:0), 1 = compare A (15:0), 2 = compare B (15:0), 3 = mode (bit 0: 0 sawtooth, 1 triangle), 4 = action word (bits 11:0).
- R3: In sawtooth mode with the generator enabled, a count of 0 is followed by the period value; any other count is followed by the count minus one.
- R4: In triangle mode, the count rises by one per clock from 0 up to the period value, then falls by one per clock back to 0, and repeats. With a period of 0 the count stays at 0.
- R5: The action word holds six 2-bit fields: bits 1:0 zero, bits 3:2 period match, bits 5:4 compare A rising, bits 7:6 compare A falling, bits 9:8 compare B rising, bits 11:10 compare B falling.
- R6: Action codes: 00 hold, 01 toggle, 10 drive low, 11 drive high. The output changes on the clock edge that ends the cycle in which the event is seen. In a cycle with no event, the output holds.
- R7: Rising-slope compare events occur only in triangle mode. A compare match is tagged by the direction the counter is moving in that cycle. In sawtooth mode every compare match is a falling event.
- R8: When a zero or period-match event coincides with a compare event, the zero or period action is applied and the compare action is dropped, even if that action is hold.
- R9: When compare A and compare B events coincide, the compare B action is applied and the compare A action is dropped.
- R10: When the period is 0, zero and period-match events coincide every cycle, and the zero action is applied.
- R11: Bits 31:12 of an action-word write are ignored.
- R12: While `gen_en` is 0, the count is held at 0 with the direction set to rising, and `pwm_out` is driven low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized to `clk` |
| gen_en | input | 1 | Generator enable; 0 parks the counter and clears the output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| pwm_out | output | 1 | Generated PWM output |
| cnt_value | output | 16 | Current counter value |

## Verification
The bench builds the block with its defaults: a 16-bit counter and a 32-bit write bus. This means the ignored upper bits of the action word can be driven and observed. The bench keeps the period small (0 to 12) so that every vector covers several full periods within a few dozen cycles. These short periods also let compare values sit exactly on zero, on the period, and on each other, which exercises every collision rule in both counting modes.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

  localparam int ACT_FIELDS = 6;
  localparam int ACT_W      = 2 * ACT_FIELDS;
  localparam int REG_ADDR_W = 3;

  // Field index inside the action word; offsets are decoded by the resolver.
  localparam int F_ZERO = 0;
  localparam int F_PER  = 1;
  localparam int F_AUP  = 2;
  localparam int F_ADN  = 3;
  localparam int F_BUP  = 4;
  localparam int F_BDN  = 5;

  localparam logic [REG_ADDR_W-1:0] ADR_PERIOD = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_CMPA   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_CMPB   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_MODE   = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADR_ACT    = 3'd4;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_FLIP = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } act_e;

  function automatic logic act_apply(act_e a, logic cur);
    case (a)
      ACT_KEEP: return cur;
      ACT_FLIP: return ~cur;
      ACT_LOW:  return 1'b0;
      default:  return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [CNT_W-1:0]      period_q,
  output logic [CNT_W-1:0]      cmpa_q,
  output logic [CNT_W-1:0]      cmpb_q,
  output logic                  mode_q,
  output logic [ACT_W-1:0]      act_q
);

  logic period_en, cmpa_en, cmpb_en, mode_en, act_en;
  logic unused_wr_hi;

  always_comb begin
    period_en = wr_en && (wr_addr == ADR_PERIOD);
    cmpa_en   = wr_en && (wr_addr == ADR_CMPA);
    cmpb_en   = wr_en && (wr_addr == ADR_CMPB);
    mode_en   = wr_en && (wr_addr == ADR_MODE);
    act_en    = wr_en && (wr_addr == ADR_ACT);
  end

  assign unused_wr_hi = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cmpa_q   <= '0;
      cmpb_q   <= '0;
      mode_q   <= 1'b0;
      act_q    <= '0;
    end else begin
      if (period_en) period_q <= wr_data[CNT_W-1:0];
      if (cmpa_en)   cmpa_q   <= wr_data[CNT_W-1:0];
      if (cmpb_en)   cmpb_q   <= wr_data[CNT_W-1:0];
      if (mode_en)   mode_q   <= wr_data[0];
      if (act_en)    act_q    <= wr_data[ACT_W-1:0];
    end
  end

  AST_ACT_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_ACT) |=> (act_q == $past(wr_data[ACT_W-1:0]))); // R11

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADR_PERIOD) |=> $stable(period_q)); // R2

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dn_eff
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             dn_q, dn_d;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    if (!en) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (!mode) begin
      dn_d  = 1'b1;
      cnt_d = (cnt_q == '0) ? period : cnt_q - ONE;
    end else if (cnt_q >= period) begin
      dn_d  = 1'b1;
      cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
    end else if (cnt_q == '0) begin
      dn_d  = 1'b0;
      cnt_d = ONE;
    end else begin
      cnt_d = dn_q ? cnt_q - ONE : cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign dn_eff = ~mode | dn_q;

  AST_SAW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode && cnt_q == '0) |=> (cnt_q == $past(period))); // R3

  AST_TRI_NEVER_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode && $past(en && mode) && cnt_q != '0 && cnt_q < period)
      |=> (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE)); // R4

  AST_PARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/pwm_event_resolve.sv
module pwm_event_resolve
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  mode,
  input  logic                  dn_eff,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [CNT_W-1:0]      period,
  input  logic [1:0][CNT_W-1:0] cmp,
  input  logic [ACT_W-1:0]      act,
  output logic                  pwm_q
);

  logic       ev_zero, ev_per;
  logic [1:0] hit_up, hit_dn;
  act_e       sel;
  logic       pwm_d;

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    logic match;
    assign match     = (cnt == cmp[g]);
    assign hit_up[g] = match & mode & ~dn_eff;
    assign hit_dn[g] = match & dn_eff;
  end

  assign ev_zero = (cnt == '0);
  assign ev_per  = (cnt == period);

  // Priority: zero, period, compare B, compare A.
  always_comb begin
    sel = ACT_KEEP;
    if (ev_zero)        sel = act_e'(act[2*F_ZERO +: 2]);
    else if (ev_per)    sel = act_e'(act[2*F_PER  +: 2]);
    else if (hit_up[1]) sel = act_e'(act[2*F_BUP  +: 2]);
    else if (hit_dn[1]) sel = act_e'(act[2*F_BDN  +: 2]);
    else if (hit_up[0]) sel = act_e'(act[2*F_AUP  +: 2]);
    else if (hit_dn[0]) sel = act_e'(act[2*F_ADN  +: 2]);
    pwm_d = en ? act_apply(sel, pwm_q) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  AST_ZERO_OVER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev_zero && act[1:0] == 2'b00) |=> $stable(pwm_q)); // R8

  AST_ZERO_OVER_PER: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev_zero && ev_per && act[1:0] == 2'b11) |=> pwm_q); // R10

  AST_B_OVER_A: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ev_zero && !ev_per && hit_dn[1] && act[11:10] == 2'b10) |=> !pwm_q); // R9

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ev_zero && !ev_per && hit_up == 2'b00 && hit_dn == 2'b00) |=> $stable(pwm_q)); // R6

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_q); // R12

endmodule

// File: rtl/pwm_event_gen.sv
module pwm_event_gen
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gen_en,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  pwm_out,
  output logic [CNT_W-1:0]      cnt_value
);

  logic [CNT_W-1:0]      period_q, cmpa_q, cmpb_q;
  logic                  mode_q, dn_eff;
  logic [ACT_W-1:0]      act_q;
  logic [1:0][CNT_W-1:0] cmp_pair;

  assign cmp_pair = {cmpb_q, cmpa_q};

  pwm_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .period_q (period_q),
    .cmpa_q   (cmpa_q),
    .cmpb_q   (cmpb_q),
    .mode_q   (mode_q),
    .act_q    (act_q)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (gen_en),
    .mode   (mode_q),
    .period (period_q),
    .cnt_q  (cnt_value),
    .dn_eff (dn_eff)
  );

  pwm_event_resolve #(.CNT_W(CNT_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (gen_en),
    .mode   (mode_q),
    .dn_eff (dn_eff),
    .cnt    (cnt_value),
    .period (period_q),
    .cmp    (cmp_pair),
    .act    (act_q),
    .pwm_q  (pwm_out)
  );

endmodule

// File: tb/pwm_event_gen_bench.sv
module pwm_event_gen_bench;

  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int NV     = 9;
  localparam int RUN    = 48;

  typedef struct packed {
    logic        mode;
    logic [15:0] per;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [11:0] act;
  } vec_t;

  // mode, period, cmpA, cmpB, action word
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd9,  16'd6, 16'd3, 12'h483}, // R3 R5: sawtooth, zero high, A-down low, B-down toggle
    '{1'b1, 16'd10, 16'd4, 16'd7, 12'h5B0}, // R4 R7: triangle, every compare slope used
    '{1'b1, 16'd8,  16'd3, 16'd3, 12'hEB0}, // R9: A and B coincide
    '{1'b1, 16'd6,  16'd0, 16'd6, 12'h55E}, // R8: compares on zero and period
    '{1'b0, 16'd5,  16'd5, 16'd0, 12'hCC1}, // R8: sawtooth compares on period and zero
    '{1'b0, 16'd7,  16'd2, 16'd4, 12'h332}, // R7: rising actions set, sawtooth mode
    '{1'b1, 16'd0,  16'd0, 16'd0, 12'h00D}, // R10: period zero
    '{1'b1, 16'd12, 16'd5, 16'd9, 12'hA6C}, // R5 R6: mixed actions
    '{1'b0, 16'd3,  16'd1, 16'd2, 12'h9A7}  // R6: short sawtooth
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 gen_en;
  logic                 wr_en;
  logic [2:0]           wr_addr;
  logic [DATA_W-1:0]    wr_data;
  logic                 pwm_out;
  logic [CNT_W-1:0]     cnt_value;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pwm_event_gen u_pwm_event_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pwm_out   (pwm_out),
    .cnt_value (cnt_value)
  );

  // Reference model built from the requirements.
  logic [15:0] m_per, m_ca, m_cb, m_cnt;
  logic        m_mode, m_dn, m_pwm;
  logic [11:0] m_act;

  function automatic logic [1:0] fld(logic [11:0] a, int i);
    return a[2*i +: 2];
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [1:0] s;
    logic       dn;
    if (!rst_n) begin
      m_per = 0; m_ca = 0; m_cb = 0; m_cnt = 0;
      m_mode = 0; m_dn = 0; m_pwm = 0; m_act = 0;
    end else begin
      dn = !m_mode || m_dn;
      if (!gen_en) begin
        m_pwm = 0; m_cnt = 0; m_dn = 0;
      end else begin
        s = 2'b00;
        if (m_cnt == 0)          s = fld(m_act, 0);
        else if (m_cnt == m_per) s = fld(m_act, 1);
        else if (m_cnt == m_cb)  s = dn ? fld(m_act, 5) : fld(m_act, 4);
        else if (m_cnt == m_ca)  s = dn ? fld(m_act, 3) : fld(m_act, 2);
        case (s)
          2'b01: m_pwm = !m_pwm;
          2'b10: m_pwm = 1'b0;
          2'b11: m_pwm = 1'b1;
          default: ;
        endcase
        if (!m_mode) begin
          m_dn = 1;
          m_cnt = (m_cnt == 0) ? m_per : m_cnt - 16'd1;
        end else if (m_cnt >= m_per) begin
          m_dn = 1;
          m_cnt = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1;
        end else if (m_cnt == 0) begin
          m_dn = 0;
          m_cnt = 16'd1;
        end else begin
          m_cnt = m_dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_per  = wr_data[15:0];
          3'd1: m_ca   = wr_data[15:0];
          3'd2: m_cb   = wr_data[15:0];
          3'd3: m_mode = wr_data[0];
          3'd4: m_act  = wr_data[11:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step_cmp();
    @(negedge clk);
    chk(pwm_out === m_pwm, "R6 R8 R9 pwm_out", 32'(pwm_out), 32'(m_pwm));
    chk(cnt_value === m_cnt, "R2 R3 R4 cnt_value", 32'(cnt_value), 32'(m_cnt));
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin : stim
    logic prev;
    rst_n = 1'b0; gen_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm_out === 1'b0, "R1 reset pwm_out", 32'(pwm_out), 0);
    chk(cnt_value === '0, "R1 reset cnt_value", 32'(cnt_value), 0);

    // R1: default configuration leaves the output low and the count at zero.
    gen_en = 1'b1;
    repeat (10) step_cmp();
    chk(pwm_out === 1'b0 && cnt_value === '0, "R1 default config",
        {15'd0, pwm_out, cnt_value}, 0);

    // Vector table walk.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); gen_en = 1'b0;
      wr(3'd3, {31'd0, VECS[i].mode});
      wr(3'd0, {16'd0, VECS[i].per});
      wr(3'd1, {16'd0, VECS[i].ca});
      wr(3'd2, {16'd0, VECS[i].cb});
      wr(3'd4, {20'd0, VECS[i].act});
      @(negedge clk); gen_en = 1'b1;
      for (int c = 0; c < RUN; c++) step_cmp();
      if (i == 5)
        chk(pwm_out === 1'b0, "R7 rising actions in sawtooth", 32'(pwm_out), 0);
      if (i == 6) begin
        // R10: zero action (toggle) wins over period action (high).
        prev = pwm_out;
        for (int c = 0; c < 4; c++) begin
          step_cmp();
          chk(pwm_out !== prev, "R10 zero beats period", 32'(pwm_out), 32'(!prev));
          prev = pwm_out;
        end
      end
    end

    // R11: upper bits of the action word are dropped.
    @(negedge clk); gen_en = 1'b0;
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd4);
    wr(3'd4, 32'hFFFF_F000);
    @(negedge clk); gen_en = 1'b1;
    for (int c = 0; c < 20; c++) step_cmp();
    chk(pwm_out === 1'b0, "R11 reserved action bits", 32'(pwm_out), 0);

    // R2: period rewritten while running; R12: disable forces low.
    wr(3'd4, 32'h0000_0003);
    for (int c = 0; c < 8; c++) step_cmp();
    wr(3'd0, 32'd6);
    for (int c = 0; c < 16; c++) step_cmp();
    chk(pwm_out === 1'b1, "R2 R6 zero drives high", 32'(pwm_out), 1);
    @(negedge clk); gen_en = 1'b0;
    @(negedge clk);
    chk(pwm_out === 1'b0, "R12 disable pwm_out", 32'(pwm_out), 0);
    chk(cnt_value === '0, "R12 disable cnt_value", 32'(cnt_value), 0);
    step_cmp();

    finish_run();
  end

endmodule